// File: doc/BRIEF.md
# Multi-format signed integer adder

This block adds or subtracts two signed integers held in any of three common signed encodings: two's complement, ones' complement and sign-magnitude. A two-bit format input tells the block how to read both operands, and the result is produced in that same encoding. Subtraction is done by negating the second operand according to the rules of the selected encoding and then adding.

Each encoding has its own addition path. Two's complement uses a plain binary adder with a carry-in. Ones' complement feeds the adder's carry-out back into the sum. Sign-magnitude compares the magnitudes, then either adds them or subtracts the smaller from the larger. All three paths run in parallel. The selected result is captured in an output register when the input strobe is high, and an output strobe marks the cycle in which a new result is presented. Besides the sum, the block reports signed overflow and, for two's complement, the carry out of the top bit, which is the unsigned overflow indication.

Top module: `multiformat_adder`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after that edge and `sum`, `ovf` and `carry` show the result of that operation. When `in_valid` is low, `out_valid` is low after the edge and `sum`, `ovf` and `carry` keep their previous values.
- R2: While `rst` is high at a clock edge, `out_valid`, `sum`, `ovf` and `carry` are all zero after that edge.
- R3: With `fmt` = 0 (two's complement), `sum` equals (A + B) modulo 2^W when `sub` = 0 and (A - B) modulo 2^W when `sub` = 1. The subtraction is formed as A + (B XOR sub-mask) + sub.
- R4: With `fmt` = 0, `ovf` is high exactly when the true signed result lies outside -2^(W-1) .. 2^(W-1)-1. Adding two operands of opposite sign never sets it.
- R5: With `fmt` = 0, `carry` is the carry out of the MSB of the adder. For addition this is A + B >= 2^W, taking both operands as unsigned. For subtraction it is A >= B unsigned, meaning no borrow.
- R6: With `fmt` = 1 (ones' complement: a negative value is the bitwise inverse of its magnitude), the adder's carry-out is added back into the low bit. `sum` is the true result reduced modulo 2^W - 1, written as a ones' complement pattern. Subtraction inverts B.
- R7: With `fmt` = 1, `ovf` is high exactly when the magnitude of the true result exceeds 2^(W-1) - 1.
- R8: With `fmt` = 2 (sign-magnitude: MSB is the sign, 1 meaning negative, and the low W-1 bits are the magnitude), operands of the same sign add their magnitudes and keep that sign. Otherwise the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. Subtraction flips the sign of B. The magnitude field is |true result| modulo 2^(W-1).
- R9: With `fmt` = 2, `ovf` is high exactly when |true result| exceeds 2^(W-1) - 1. Operands of opposite effective sign never set it.
- R10: A zero result is always the all-zeros pattern. Ones' complement never outputs all ones, and sign-magnitude never outputs a sign of 1 with a magnitude of zero. Negative-zero operands are read as zero.
- R11: `carry` is zero for `fmt` = 1 and `fmt` = 2. The code `fmt` = 3 behaves exactly like two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| fmt | input | 2 | Encoding: 0 two's, 1 ones', 2 sign-magnitude, 3 two's |
| sub | input | 1 | 1 selects A - B, 0 selects A + B |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Registered result is new this cycle |
| sum | output | W | Result in the selected encoding |
| ovf | output | 1 | Signed overflow |
| carry | output | 1 | Carry out of MSB (two's complement only) |

## Verification
Every result is due exactly one clock edge after the edge that samples `in_valid`. The bench drives operands just after a falling edge. It reads `out_valid`, `sum`, `ovf` and `carry` at the following falling edge, which falls after the one capturing register has loaded. Because of this, a vector can be applied on every cycle without overlapping the check of the previous one. An idle cycle is followed by a read at the next falling edge, which confirms that the register did not reload. The reset state is read at a falling edge while reset is still high.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic [1:0] {
    FMT_TWOS = 2'd0,
    FMT_ONES = 2'd1,
    FMT_SMAG = 2'd2,
    FMT_TWO2 = 2'd3
  } fmt_e;
endpackage

// File: rtl/mfa_negate.sv
module mfa_negate
  import mfa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   fmt,
  input  logic         sub,
  input  logic [W-1:0] b,
  output logic [W-1:0] b_eff,
  output logic         cin
);
  always_comb begin
    b_eff = b;
    cin   = 1'b0;
    unique case (fmt_e'(fmt))
      FMT_ONES: b_eff = sub ? ~b : b;
      FMT_SMAG: b_eff = {b[W-1] ^ sub, b[W-2:0]};
      default: begin
        // two's: controlled inversion plus carry-in
        b_eff = b ^ {W{sub}};
        cin   = sub;
      end
    endcase
  end
endmodule

// File: rtl/mfa_twos_path.sv
module mfa_twos_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         ovf,
  output logic         cout
);
  logic [W:0] raw;
  always_comb begin
    raw  = {1'b0, a} + {1'b0, b_eff} + (W+1)'(cin);
    s    = raw[W-1:0];
    cout = raw[W];
    ovf  = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);
  end
endmodule

// File: rtl/mfa_ones_path.sv
module mfa_ones_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  output logic [W-1:0] s,
  output logic         ovf
);
  logic [W:0]   raw;
  logic [W-1:0] wrap;
  always_comb begin
    raw  = {1'b0, a} + {1'b0, b_eff};
    wrap = raw[W-1:0] + W'(raw[W]);
    ovf  = (a[W-1] == b_eff[W-1]) && (wrap[W-1] != a[W-1]);
    s    = (&wrap) ? '0 : wrap;
  end
endmodule

// File: rtl/mfa_smag_path.sv
module mfa_smag_path #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  output logic [W-1:0] s,
  output logic         ovf
);
  localparam int MW = W - 1;

  logic [MW-1:0] ma, mb, diff, mag;
  logic [MW:0]   msum;
  logic          sa, sb, same, a_ge, sgn;

  always_comb begin
    sa   = a[W-1];
    sb   = b_eff[W-1];
    ma   = a[MW-1:0];
    mb   = b_eff[MW-1:0];
    same = (sa == sb);
    a_ge = (ma >= mb);
    msum = {1'b0, ma} + {1'b0, mb};
    diff = a_ge ? (ma - mb) : (mb - ma);
    mag  = same ? msum[MW-1:0] : diff;
    sgn  = same ? sa : (a_ge ? sa : sb);
    ovf  = same && msum[MW];
    s    = (mag == '0) ? '0 : {sgn, mag};
  end
endmodule

// File: rtl/multiformat_adder.sv
module multiformat_adder
  import mfa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [1:0]   fmt,
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         ovf,
  output logic         carry
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] s_two, s_one, s_sm, s_sel;
  logic         o_two, o_one, o_sm, o_sel, c_two, c_sel;

  mfa_negate #(.W(W)) u_neg (
    .fmt(fmt), .sub(sub), .b(b), .b_eff(b_eff), .cin(cin)
  );

  mfa_twos_path #(.W(W)) u_two (
    .a(a), .b_eff(b_eff), .cin(cin), .s(s_two), .ovf(o_two), .cout(c_two)
  );

  mfa_ones_path #(.W(W)) u_one (
    .a(a), .b_eff(b_eff), .s(s_one), .ovf(o_one)
  );

  mfa_smag_path #(.W(W)) u_sm (
    .a(a), .b_eff(b_eff), .s(s_sm), .ovf(o_sm)
  );

  always_comb begin
    unique case (fmt_e'(fmt))
      FMT_ONES: begin s_sel = s_one; o_sel = o_one; c_sel = 1'b0; end
      FMT_SMAG: begin s_sel = s_sm;  o_sel = o_sm;  c_sel = 1'b0; end
      default:  begin s_sel = s_two; o_sel = o_two; c_sel = c_two; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      sum       <= '0;
      ovf       <= 1'b0;
      carry     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum   <= s_sel;
        ovf   <= o_sel;
        carry <= c_sel;
      end
    end
  end
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [1:0]   fmt,
  input logic         sub,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         out_valid,
  input logic [W-1:0] sum,
  input logic         ovf,
  input logic         carry
);
  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  strobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(sum) && $stable(ovf) && $stable(carry)));
  // R4
  mixed_sign_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fmt[1] && !fmt[0] && !sub && (a[W-1] != b[W-1])) |=> !ovf);
  // R9
  smag_mixed_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == 2'd2 && (a[W-1] != (b[W-1] ^ sub))) |=> !ovf);
  // R10
  ones_negzero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == 2'd1) |=> (sum != {W{1'b1}}));
  // R10
  smag_negzero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt == 2'd2) |=> (sum != {1'b1, {(W-1){1'b0}}}));
  // R11
  carry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (fmt == 2'd1 || fmt == 2'd2)) |=> !carry);
endmodule

bind multiformat_adder mfa_checker #(.W(W)) u_mfa_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt), .sub(sub),
  .a(a), .b(b), .out_valid(out_valid), .sum(sum), .ovf(ovf), .carry(carry)
);

// File: tb/tb_multiformat_adder.sv
module tb_multiformat_adder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  // 4-bit instance for exhaustive sweep
  logic       v4 = 1'b0, s4 = 1'b0;
  logic [1:0] f4 = '0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       ov4, o4, c4;
  logic [3:0] q4;

  multiformat_adder #(.W(4)) dut (
    .clk(clk), .rst(rst), .in_valid(v4), .fmt(f4), .sub(s4), .a(a4), .b(b4),
    .out_valid(ov4), .sum(q4), .ovf(o4), .carry(c4)
  );

  // 8-bit instance for strided and directed vectors
  logic       v8 = 1'b0, s8 = 1'b0;
  logic [1:0] f8 = '0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       ov8, o8, c8;
  logic [7:0] q8;

  multiformat_adder #(.W(8)) dut_w8 (
    .clk(clk), .rst(rst), .in_valid(v8), .fmt(f8), .sub(s8), .a(a8), .b(b8),
    .out_valid(ov8), .sum(q8), .ovf(o8), .carry(c8)
  );

  function automatic int decode(int f, int x, int w);
    int p = 1 << w, h = 1 << (w - 1);
    if (f == 1) return (x >= h) ? -((p - 1) - x) : x;
    if (f == 2) return (x >= h) ? -(x - h) : x;
    return (x >= h) ? x - p : x;
  endfunction

  task automatic expect_of(input int f, input int sb, input int x, input int y,
                           input int w, output int es, output int eo, output int ec);
    int p = 1 << w, h = 1 << (w - 1), m = (1 << (w - 1)) - 1;
    int t = decode(f, x, w) + (sb ? -decode(f, y, w) : decode(f, y, w));
    int at = (t < 0) ? -t : t;
    if (f == 1) begin
      es = ((t % (p - 1)) + (p - 1)) % (p - 1);
      eo = (at > m) ? 1 : 0;
      ec = 0;
    end else if (f == 2) begin
      int fm = at % h;
      es = (fm == 0) ? 0 : (((t < 0) ? h : 0) + fm);
      eo = (at > m) ? 1 : 0;
      ec = 0;
    end else begin
      es = ((t % p) + p) % p;
      eo = (t > h - 1 || t < -h) ? 1 : 0;
      ec = sb ? ((x >= y) ? 1 : 0) : ((x + y >= p) ? 1 : 0);
    end
  endtask

  task automatic compare(input int f, input int sb, input int x, input int y, input int w,
                         input int gv, input int gs, input int go, input int gc);
    int es, eo, ec;
    string tg_s, tg_o, tg_c;
    expect_of(f, sb, x, y, w, es, eo, ec);
    n_vec++;
    tg_s = (f == 1) ? "R6" : (f == 2) ? "R8" : "R3";
    if (es == 0 && (f == 1 || f == 2)) tg_s = "R10";
    tg_o = (f == 1) ? "R7" : (f == 2) ? "R9" : "R4";
    tg_c = (f == 1 || f == 2) ? "R11" : (f == 3) ? "R11" : "R5";
    if (gv != 1) begin
      n_bad++;
      $display("FAIL R1 w%0d out_valid got %0d exp 1", w, gv);
    end else if (gs != es) begin
      n_bad++;
      $display("FAIL %s w%0d f%0d sub%0d a=%0h b=%0h sum got %0h exp %0h",
               tg_s, w, f, sb, x, y, gs, es);
    end else if (go != eo) begin
      n_bad++;
      $display("FAIL %s w%0d f%0d sub%0d a=%0h b=%0h ovf got %0d exp %0d",
               tg_o, w, f, sb, x, y, go, eo);
    end else if (gc != ec) begin
      n_bad++;
      $display("FAIL %s w%0d f%0d sub%0d a=%0h b=%0h carry got %0d exp %0d",
               tg_c, w, f, sb, x, y, gc, ec);
    end
  endtask

  task automatic run8(input int f, input int sb, input int x, input int y);
    v8 = 1'b1; f8 = 2'(f); s8 = 1'(sb); a8 = 8'(x); b8 = 8'(y);
    @(negedge clk);
    compare(f, sb, x, y, 8, int'(ov8), int'(q8), int'(o8), int'(c8));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] held;
    repeat (3) @(negedge clk);
    // R2: reset state
    n_vec++;
    if (ov4 !== 1'b0 || q4 !== 4'd0 || o4 !== 1'b0 || c4 !== 1'b0 ||
        ov8 !== 1'b0 || q8 !== 8'd0) begin
      n_bad++;
      $display("FAIL R2 reset outputs got v%b s%h o%b c%b exp all zero", ov4, q4, o4, c4);
    end
    rst = 1'b0;
    @(negedge clk);

    // Exhaustive 4-bit sweep: R3..R11 and R1 back-to-back
    for (int f = 0; f < 4; f++)
      for (int sb = 0; sb < 2; sb++)
        for (int x = 0; x < 16; x++)
          for (int y = 0; y < 16; y++) begin
            v4 = 1'b1; f4 = 2'(f); s4 = 1'(sb); a4 = 4'(x); b4 = 4'(y);
            @(negedge clk);
            compare(f, sb, x, y, 4, int'(ov4), int'(q4), int'(o4), int'(c4));
          end

    // R1: idle cycle keeps result and drops strobe
    held = q4;
    v4 = 1'b0; a4 = 4'h3; b4 = 4'h2; f4 = 2'd0; s4 = 1'b0;
    @(negedge clk);
    n_vec++;
    if (ov4 !== 1'b0 || q4 !== held) begin
      n_bad++;
      $display("FAIL R1 idle got v%b s%h exp v0 s%h", ov4, q4, held);
    end

    // 8-bit directed: R4 example -120 + -17, R10 negative zeros
    run8(0, 0, 8'h88, 8'hEF);
    run8(0, 1, 8'h00, 8'h80);
    run8(1, 0, 8'hFF, 8'hFF);
    run8(1, 1, 8'h05, 8'h05);
    run8(2, 0, 8'h80, 8'h80);
    run8(2, 1, 8'h85, 8'h85);
    run8(2, 0, 8'h7F, 8'h01);
    // 8-bit strided sweep
    for (int f = 0; f < 4; f++)
      for (int sb = 0; sb < 2; sb++)
        for (int x = 0; x < 256; x += 17)
          for (int y = 0; y < 256; y += 13)
            run8(f, sb, x, y);
    v8 = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule